// File: doc/BRIEF.md
# Paged Memory Management Unit

This block maps 16-bit virtual addresses to physical addresses through per-mode page tables. Each of the kernel, supervisor and user modes owns eight pages. Each page has a base register, counted in 64-byte units, and a descriptor register. The descriptor holds the page length, a growth direction and a permission code.

When mapping is switched on, every access is checked in the same cycle against three rules: the page permission, the page length, and the amount of installed memory. A failed check produces an abort pulse with a trap vector and leaves sticky status behind. When mapping is off, addresses pass through unchanged.

All page registers and the two control registers are held locally. They are reached through a simple word/byte register port. Two sets of page registers exist per mode. Only the first set takes part in translation; the second set is storage only.

Top module: `paged_mmu`

## Requirements
- R1: While control register 0 bit 0 is clear, `paddr_o` equals `vaddr_i` zero-extended, and `abort_o` stays low.
- R2: While control register 0 bit 0 is set, the page is selected by `vaddr_i[15:13]`. `paddr_o` equals the page base register times 64 plus `vaddr_i[12:0]`.
- R3: The translation mode is taken from `psw_mode_i[3:2]`, or from `psw_mode_i[1:0]` when `acc_prev_i` is high. Code 0 selects kernel, 1 selects supervisor and 3 selects user.
- R4: The page length is (descriptor[14:8]+1)*64 bytes.
  - With descriptor bit 3 clear, an offset at or above the length aborts.
  - With bit 3 set, an offset below the length aborts.
  - This abort uses vector octal 250 and sets control register 0 bit 14.
- R5: The permission code is descriptor[2:0]. It is checked only when control register 0 bit 9 is set and `acc_peek_i` is low.
  - A write passes only with code 6.
  - A read fails with code 0, 1, 3, 4 or 7.
- R6: A permission abort uses vector octal 4. It sets control register 0 bits 13 and 12 and writes the faulting mode into bits 6:5.
- R7: A translated address at or above MEM_BYTES aborts with vector octal 4 and sets control register 0 bit 15.
- R8: Abort priority and side effects:
  - Priority is permission, then non-resident, then length.
  - Any abort sets bit 7 of the descriptor of the faulting page in the first set.
  - `abort_o` is raised only with `acc_valid_i` high.
  - `trap_vec_o` is 0 while `abort_o` is low.
- R9: Register addresses (octal):
  - supervisor descriptors at 172200, supervisor bases at 172240
  - kernel descriptors at 172300, kernel bases at 172340
  - user descriptors at 177600, user bases at 177640
  - control register 0 at 177572, control register 3 at 172516
  - Within a page block, address bit 4 picks the set and bits 3:1 pick the page.
  - Written values read back subject to R11 and R12. The second set never affects translation.
- R10: With `reg_byte_i` high, an odd address writes the high byte and an even address writes the low byte. The other byte is kept. A byte read returns the addressed byte in bits 7:0 with bits 15:8 zero.
- R11: Write masks for page registers:
  - Descriptor writes clear bits 7:4.
  - With LEGACY set, descriptor writes are also masked with octal 077516.
  - With LEGACY set, base register writes keep only bits 11:0.
- R12: Write rules for the control registers:
  - A write to control register 0 clears bits 11:10.
  - If the written value has bit 0 set, it also clears bits 15:13.
  - Control register 3 keeps only the bits of octal 067.
- R13: An active-low reset clears both control registers and every page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high, read when low |
| reg_byte_i | input | 1 | Byte access; address bit 0 picks the half |
| reg_addr_i | input | 16 | Register address |
| reg_wdata_i | input | 16 | Write data (byte data in bits 7:0) |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| reg_hit_o | output | 1 | `reg_addr_i` decodes to a register |
| acc_valid_i | input | 1 | Memory access strobe |
| acc_write_i | input | 1 | Access is a write |
| acc_peek_i | input | 1 | Access bypasses the permission check |
| acc_prev_i | input | 1 | Translate with the previous mode field |
| psw_mode_i | input | 4 | Processor status bits 15:12 |
| vaddr_i | input | 16 | Virtual address |
| paddr_o | output | PA_W | Physical address |
| abort_o | output | 1 | Access aborted this cycle |
| trap_vec_o | output | 8 | Trap vector of the abort, else 0 |

## Verification
The main instance is built with the default parameters: MEM_BYTES of 128 KiB, a 22-bit physical address and LEGACY clear. Random base values up to 12 bits then land pages beyond installed memory about half the time. This makes non-resident aborts, and their ordering against permission and length aborts, frequent.

A second instance with LEGACY set shares the same register bus. Its readback exposes the narrower masks.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    RK_PDR  = 2'd0,
    RK_PAR  = 2'd1,
    RK_CTL0 = 2'd2,
    RK_CTL3 = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [1:0] mode;
    logic      dset;
    logic [2:0] page;
  } reg_dec_t;

  typedef struct packed {
    logic       valid;
    logic       acc;
    logic       nonres;
    logic       len;
    logic [1:0] mode;
    logic [2:0] page;
  } fault_t;

  localparam logic [15:0] A_CTL0 = 16'o177572;
  localparam logic [15:0] A_CTL3 = 16'o172516;
  localparam logic [7:0]  VEC_ACC = 8'o004;
  localparam logic [7:0]  VEC_LEN = 8'o250;

  // 32-byte register blocks, keyed by address bits 15:5
  function automatic reg_dec_t decode_reg(input logic [15:0] a);
    reg_dec_t d;
    d      = '0;
    d.hit  = 1'b1;
    d.dset = a[4];
    d.page = a[3:1];
    case (a[15:5])
      11'h7A4: begin d.kind = RK_PDR; d.mode = 2'd1; end
      11'h7A5: begin d.kind = RK_PAR; d.mode = 2'd1; end
      11'h7A6: begin d.kind = RK_PDR; d.mode = 2'd0; end
      11'h7A7: begin d.kind = RK_PAR; d.mode = 2'd0; end
      11'h7FC: begin d.kind = RK_PDR; d.mode = 2'd3; end
      11'h7FD: begin d.kind = RK_PAR; d.mode = 2'd3; end
      default: begin
        if (a[15:1] == A_CTL0[15:1])      d.kind = RK_CTL0;
        else if (a[15:1] == A_CTL3[15:1]) d.kind = RK_CTL3;
        else                              d.hit  = 1'b0;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mmu_regs.sv
module mmu_regs
  import mmu_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_sel_i,
  input  logic        reg_we_i,
  input  logic        reg_byte_i,
  input  logic [15:0] reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        reg_hit_o,
  input  logic [1:0]  look_mode_i,
  input  logic [2:0]  look_page_i,
  output logic [15:0] look_pdr_o,
  output logic [15:0] look_par_o,
  output logic [15:0] ctl0_o,
  input  fault_t      flt_i
);
  localparam int N_MODE = 4;
  localparam int N_SET  = 2;
  localparam int N_PAGE = 8;
  localparam logic [15:0] PDR_KEEP = LEGACY ? (16'o077516 & 16'hFF0F) : 16'hFF0F;
  localparam logic [15:0] PAR_KEEP = LEGACY ? 16'h0FFF : 16'hFFFF;
  localparam logic [15:0] CTL3_KEEP = 16'o000067;

  logic [15:0] pdr_q [N_MODE][N_SET][N_PAGE];
  logic [15:0] par_q [N_MODE][N_SET][N_PAGE];
  logic [15:0] ctl0_q, ctl3_q;

  reg_dec_t    dec;
  logic [15:0] cur, merged, wr_val, ctl0_tmp;
  logic        wr_en;

  assign dec   = decode_reg(reg_addr_i);
  assign wr_en = reg_sel_i & reg_we_i & dec.hit;

  always_comb begin
    unique case (dec.kind)
      RK_PDR:  cur = pdr_q[dec.mode][dec.dset][dec.page];
      RK_PAR:  cur = par_q[dec.mode][dec.dset][dec.page];
      RK_CTL0: cur = ctl0_q;
      default: cur = ctl3_q;
    endcase
  end

  always_comb begin
    if (!reg_byte_i)        merged = reg_wdata_i;
    else if (reg_addr_i[0]) merged = {reg_wdata_i[7:0], cur[7:0]};
    else                    merged = {cur[15:8], reg_wdata_i[7:0]};
    ctl0_tmp = merged & ~16'h0C00;
    if (ctl0_tmp[0]) ctl0_tmp = ctl0_tmp & 16'h1FFF;
    unique case (dec.kind)
      RK_PDR:  wr_val = merged & PDR_KEEP;
      RK_PAR:  wr_val = merged & PAR_KEEP;
      RK_CTL0: wr_val = ctl0_tmp;
      default: wr_val = merged & CTL3_KEEP;
    endcase
  end

  always_comb begin
    if (!dec.hit)        reg_rdata_o = '0;
    else if (!reg_byte_i) reg_rdata_o = cur;
    else                 reg_rdata_o = {8'h00, reg_addr_i[0] ? cur[15:8] : cur[7:0]};
  end
  assign reg_hit_o = dec.hit;

  assign look_pdr_o = pdr_q[look_mode_i][0][look_page_i];
  assign look_par_o = par_q[look_mode_i][0][look_page_i];
  assign ctl0_o     = ctl0_q;

  // fault recording first; a register write in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < N_MODE; m++)
        for (int s = 0; s < N_SET; s++)
          for (int p = 0; p < N_PAGE; p++) begin
            pdr_q[m][s][p] <= '0;
            par_q[m][s][p] <= '0;
          end
      ctl0_q <= '0;
      ctl3_q <= '0;
    end else begin
      if (flt_i.valid) begin
        pdr_q[flt_i.mode][0][flt_i.page][7] <= 1'b1;
        if (flt_i.acc) begin
          ctl0_q[13:12] <= 2'b11;
          ctl0_q[6:5]   <= flt_i.mode;
        end
        if (flt_i.nonres) ctl0_q[15] <= 1'b1;
        if (flt_i.len)    ctl0_q[14] <= 1'b1;
      end
      if (wr_en) begin
        unique case (dec.kind)
          RK_PDR:  pdr_q[dec.mode][dec.dset][dec.page] <= wr_val;
          RK_PAR:  par_q[dec.mode][dec.dset][dec.page] <= wr_val;
          RK_CTL0: ctl0_q <= wr_val;
          default: ctl3_q <= wr_val;
        endcase
      end
    end
  end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int PA_W      = 22,
  parameter int MEM_BYTES = 131072
) (
  input  logic            acc_valid_i,
  input  logic            acc_write_i,
  input  logic            acc_peek_i,
  input  logic [15:0]     vaddr_i,
  input  logic [1:0]      mode_i,
  input  logic [15:0]     pdr_i,
  input  logic [15:0]     par_i,
  input  logic            map_en_i,
  input  logic            perm_en_i,
  output logic [PA_W-1:0] paddr_o,
  output logic            abort_o,
  output logic [7:0]      trap_vec_o,
  output fault_t          flt_o
);
  localparam int SUM_W = PA_W + 1;

  logic [SUM_W-1:0] phys;
  logic [13:0]      len_b;
  logic [12:0]      off;
  logic [2:0]       code;
  logic             perm_bad, len_bad, nonres;
  logic             f_acc, f_nr, f_len;
  logic             unused_pdr;

  assign unused_pdr = ^{pdr_i[15], pdr_i[7:4]};

  assign off   = vaddr_i[12:0];
  assign code  = pdr_i[2:0];
  assign phys  = SUM_W'({par_i, 6'd0}) + SUM_W'(off);
  assign len_b = {({1'b0, pdr_i[14:8]} + 8'd1), 6'd0};

  always_comb begin
    if (acc_write_i) perm_bad = (code != 3'd6);
    else             perm_bad = (code == 3'd0) || (code == 3'd1) || (code == 3'd3) ||
                                (code == 3'd4) || (code == 3'd7);
  end

  assign len_bad = pdr_i[3] ? ({1'b0, off} < len_b) : ({1'b0, off} >= len_b);
  assign nonres  = phys >= SUM_W'(MEM_BYTES);

  assign f_acc = map_en_i & perm_en_i & ~acc_peek_i & perm_bad;
  assign f_nr  = map_en_i & ~f_acc & nonres;
  assign f_len = map_en_i & ~f_acc & ~nonres & len_bad;

  assign abort_o    = acc_valid_i & (f_acc | f_nr | f_len);
  assign trap_vec_o = !abort_o ? 8'd0 : (f_len ? VEC_LEN : VEC_ACC);
  assign paddr_o    = map_en_i ? phys[PA_W-1:0] : PA_W'(vaddr_i);

  always_comb begin
    flt_o        = '0;
    flt_o.valid  = abort_o;
    flt_o.acc    = f_acc;
    flt_o.nonres = f_nr;
    flt_o.len    = f_len;
    flt_o.mode   = mode_i;
    flt_o.page   = vaddr_i[15:13];
  end

endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import mmu_pkg::*;
#(
  parameter int PA_W      = 22,
  parameter int MEM_BYTES = 131072,
  parameter bit LEGACY    = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_sel_i,
  input  logic            reg_we_i,
  input  logic            reg_byte_i,
  input  logic [15:0]     reg_addr_i,
  input  logic [15:0]     reg_wdata_i,
  output logic [15:0]     reg_rdata_o,
  output logic            reg_hit_o,
  input  logic            acc_valid_i,
  input  logic            acc_write_i,
  input  logic            acc_peek_i,
  input  logic            acc_prev_i,
  input  logic [3:0]      psw_mode_i,
  input  logic [15:0]     vaddr_i,
  output logic [PA_W-1:0] paddr_o,
  output logic            abort_o,
  output logic [7:0]      trap_vec_o
);
  logic [1:0]  mode;
  logic [15:0] pdr, par, ctl0;
  fault_t      flt;
  logic        ctl0_wr;
  logic        unused_ctl0;

  assign mode        = acc_prev_i ? psw_mode_i[1:0] : psw_mode_i[3:2];
  assign ctl0_wr     = reg_sel_i & reg_we_i & (reg_addr_i[15:1] == A_CTL0[15:1]);
  assign unused_ctl0 = ^ctl0;

  mmu_regs #(.LEGACY(LEGACY)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_sel_i   (reg_sel_i),
    .reg_we_i    (reg_we_i),
    .reg_byte_i  (reg_byte_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .reg_hit_o   (reg_hit_o),
    .look_mode_i (mode),
    .look_page_i (vaddr_i[15:13]),
    .look_pdr_o  (pdr),
    .look_par_o  (par),
    .ctl0_o      (ctl0),
    .flt_i       (flt)
  );

  mmu_xlate #(.PA_W(PA_W), .MEM_BYTES(MEM_BYTES)) i_xlate (
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_peek_i  (acc_peek_i),
    .vaddr_i     (vaddr_i),
    .mode_i      (mode),
    .pdr_i       (pdr),
    .par_i       (par),
    .map_en_i    (ctl0[0]),
    .perm_en_i   (ctl0[9]),
    .paddr_o     (paddr_o),
    .abort_o     (abort_o),
    .trap_vec_o  (trap_vec_o),
    .flt_o       (flt)
  );

  p_unmapped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !ctl0[0]) |-> (!abort_o && paddr_o == PA_W'(vaddr_i)));

  p_abort_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> acc_valid_i);

  p_vec_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (trap_vec_o == VEC_ACC || trap_vec_o == VEC_LEN));

  p_perm_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt.acc && abort_o && !ctl0_wr) |=> (ctl0[13:12] == 2'b11 && ctl0[6:5] == $past(mode)));

  p_ctl0_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl0_wr |=> (ctl0[11:10] == 2'b00));

endmodule

// File: tb/test_paged_mmu.sv
module test_paged_mmu;
  localparam int CLK_P     = 10;
  localparam int PA_W      = 22;
  localparam int MEM_BYTES = 131072;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 0, reg_we = 0, reg_byte = 0;
  logic [15:0] reg_addr = '0, reg_wdata = '0;
  logic [15:0] rdata, lg_rdata;
  logic hit, lg_hit;
  logic acc_valid = 0, acc_write = 0, acc_peek = 0, acc_prev = 0;
  logic [15:0] psw = '0, vaddr = '0;
  logic [PA_W-1:0] paddr, lg_paddr;
  logic abort, lg_abort;
  logic [7:0] vec, lg_vec;

  always #(CLK_P/2) clk = ~clk;

  paged_mmu #(.PA_W(PA_W), .MEM_BYTES(MEM_BYTES), .LEGACY(1'b0)) i_paged_mmu (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .reg_we_i(reg_we),
    .reg_byte_i(reg_byte), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .reg_hit_o(hit), .acc_valid_i(acc_valid),
    .acc_write_i(acc_write), .acc_peek_i(acc_peek), .acc_prev_i(acc_prev),
    .psw_mode_i(psw[15:12]), .vaddr_i(vaddr), .paddr_o(paddr),
    .abort_o(abort), .trap_vec_o(vec));

  paged_mmu #(.PA_W(PA_W), .MEM_BYTES(MEM_BYTES), .LEGACY(1'b1)) i_paged_mmu_lg (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .reg_we_i(reg_we),
    .reg_byte_i(reg_byte), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(lg_rdata), .reg_hit_o(lg_hit), .acc_valid_i(acc_valid),
    .acc_write_i(acc_write), .acc_peek_i(acc_peek), .acc_prev_i(acc_prev),
    .psw_mode_i(psw[15:12]), .vaddr_i(vaddr), .paddr_o(lg_paddr),
    .abort_o(lg_abort), .trap_vec_o(lg_vec));

  logic [15:0] m_pdr [4][2][8];
  logic [15:0] m_par [4][2][8];
  logic [15:0] m_ctl0, m_ctl3;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic m_clear();
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 8; p++) begin
          m_pdr[m][s][p] = '0;
          m_par[m][s][p] = '0;
        end
    m_ctl0 = '0;
    m_ctl3 = '0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind: 0 descriptor, 1 base, 2 control 0, 3 control 3
  function automatic logic [15:0] addr_of(int kind, int mode, bit dset, int page);
    logic [15:0] b;
    if (kind == 2) return 16'o177572;
    if (kind == 3) return 16'o172516;
    case (mode)
      0:       b = (kind == 0) ? 16'o172300 : 16'o172340;
      1:       b = (kind == 0) ? 16'o172200 : 16'o172240;
      default: b = (kind == 0) ? 16'o177600 : 16'o177640;
    endcase
    return b | {11'd0, dset, page[2:0], 1'b0};
  endfunction

  function automatic logic [15:0] m_get(int kind, int mode, bit dset, int page);
    case (kind)
      0: return m_pdr[mode][dset][page];
      1: return m_par[mode][dset][page];
      2: return m_ctl0;
      default: return m_ctl3;
    endcase
  endfunction

  task automatic do_write(int kind, int mode, bit dset, int page, bit bm, bit odd, logic [15:0] d);
    logic [15:0] cur, mg;
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_byte = bm;
    reg_addr = addr_of(kind, mode, dset, page) | {15'd0, odd};
    reg_wdata = bm ? {8'h00, d[7:0]} : d;
    @(posedge clk); #1;
    reg_sel = 0; reg_we = 0; reg_byte = 0;
    cur = m_get(kind, mode, dset, page);
    mg = !bm ? d : (odd ? {d[7:0], cur[7:0]} : {cur[15:8], d[7:0]});
    case (kind)
      0: m_pdr[mode][dset][page] = mg & 16'hFF0F;
      1: m_par[mode][dset][page] = mg;
      2: begin
        mg = mg & ~16'h0C00;
        if (mg[0]) mg = mg & 16'h1FFF;
        m_ctl0 = mg;
      end
      default: m_ctl3 = mg & 16'o67;
    endcase
  endtask

  task automatic do_read(int kind, int mode, bit dset, int page, bit bm, bit odd, string req);
    logic [15:0] v, e;
    @(negedge clk);
    reg_sel = 1; reg_we = 0; reg_byte = bm;
    reg_addr = addr_of(kind, mode, dset, page) | {15'd0, odd};
    #2;
    v = m_get(kind, mode, dset, page);
    e = !bm ? v : (odd ? {8'h00, v[15:8]} : {8'h00, v[7:0]});
    chk(req, "rdata", {16'd0, rdata}, {16'd0, e});
    chk(req, "hit", {31'd0, hit}, 32'd1);
    @(posedge clk); #1;
    reg_sel = 0; reg_byte = 0;
  endtask

  task automatic lg_read(logic [15:0] a, logic [15:0] e, string req);
    @(negedge clk);
    reg_sel = 1; reg_we = 0; reg_byte = 0; reg_addr = a;
    #2;
    chk(req, "legacy rdata", {16'd0, lg_rdata}, {16'd0, e});
    @(posedge clk); #1;
    reg_sel = 0;
  endtask

  task automatic do_acc(logic [15:0] va, logic [15:0] ps, bit prev, bit wr, bit pk, string req);
    int md, pg, fk;
    int unsigned off, ph, ln;
    logic [15:0] pd;
    logic [2:0] ac;
    bit perm, nr, lb, ab;
    logic [PA_W-1:0] pa;
    logic [7:0] ev;
    md = prev ? int'(ps[13:12]) : int'(ps[15:14]);
    pg = int'(va[15:13]);
    off = va[12:0];
    pd = m_pdr[md][0][pg];
    ph = m_par[md][0][pg] * 64 + off;
    ln = (pd[14:8] + 1) * 64;
    ac = pd[2:0];
    fk = 0;
    if (m_ctl0[0]) begin
      perm = m_ctl0[9] && !pk && (wr ? (ac != 3'd6) : (ac == 0 || ac == 1 || ac == 3 || ac == 4 || ac == 7));
      nr = ph >= MEM_BYTES;
      lb = pd[3] ? (off < ln) : (off >= ln);
      if (perm) fk = 1; else if (nr) fk = 2; else if (lb) fk = 3;
      pa = ph[PA_W-1:0];
    end else pa = PA_W'(va);
    ab = (fk != 0);
    ev = (fk == 0) ? 8'd0 : (fk == 3 ? 8'o250 : 8'o004);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_peek = pk; acc_prev = prev; psw = ps; vaddr = va;
    #2;
    chk(req, "paddr", {10'd0, paddr}, {10'd0, pa});
    chk(req, "abort", {31'd0, abort}, {31'd0, ab});
    chk(req, "vector", {24'd0, vec}, {24'd0, ev});
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; acc_peek = 0; acc_prev = 0;
    if (ab) begin
      m_pdr[md][0][pg][7] = 1'b1;
      case (fk)
        1: begin m_ctl0[13:12] = 2'b11; m_ctl0[6:5] = md[1:0]; end
        2: m_ctl0[15] = 1'b1;
        default: m_ctl0[14] = 1'b1;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_clear();
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R13 reset state
    do_read(2, 0, 0, 0, 0, 0, "R13");
    do_read(0, 0, 0, 0, 0, 0, "R13");
    do_read(1, 3, 1, 7, 0, 0, "R13");
    // R1 identity while unmapped
    do_acc(16'o177777, 16'hC000, 0, 1, 0, "R1");
    do_acc(16'h1234, 16'h0000, 0, 0, 0, "R1");
    // R9 map and R2 translation
    do_write(1, 0, 0, 1, 0, 0, 16'd100);
    do_write(0, 0, 0, 1, 0, 0, 16'h7F06);
    do_read(1, 0, 0, 1, 0, 0, "R9");
    do_read(0, 0, 0, 1, 0, 0, "R9");
    do_write(2, 0, 0, 0, 0, 0, 16'h0001);
    do_acc(16'h2123, 16'h0000, 0, 0, 0, "R2");
    do_acc(16'h3FFF, 16'h0000, 0, 1, 0, "R2");
    // R3 mode select
    do_write(1, 3, 0, 1, 0, 0, 16'd200);
    do_write(0, 3, 0, 1, 0, 0, 16'h7F06);
    do_acc(16'h2040, 16'hC000, 0, 0, 0, "R3");
    do_acc(16'h2040, 16'h3000, 1, 0, 0, "R3");
    do_acc(16'h2040, 16'h3000, 0, 0, 0, "R3");
    // R9 second set is not used for translation
    do_write(1, 0, 1, 1, 0, 0, 16'd900);
    do_read(1, 0, 1, 1, 0, 0, "R9");
    do_acc(16'h2010, 16'h0000, 0, 0, 0, "R9");
    // R4 expand up, length 256 bytes
    do_write(1, 1, 0, 2, 0, 0, 16'd10);
    do_write(0, 1, 0, 2, 0, 0, 16'h0306);
    do_acc(16'h40FF, 16'h4000, 0, 0, 0, "R4");
    do_acc(16'h4100, 16'h4000, 0, 0, 0, "R4");
    do_read(2, 0, 0, 0, 0, 0, "R4");
    do_read(0, 1, 0, 2, 0, 0, "R8");
    // R4 expand down
    do_write(0, 1, 0, 2, 0, 0, 16'h030E);
    do_acc(16'h40FF, 16'h4000, 0, 0, 0, "R4");
    do_acc(16'h4100, 16'h4000, 0, 0, 0, "R4");
    // R12 clearing of error bits
    do_write(2, 0, 0, 0, 0, 0, 16'hE001);
    do_read(2, 0, 0, 0, 0, 0, "R12");
    // R5 and R6 permission checks
    do_write(2, 0, 0, 0, 0, 0, 16'h0201);
    do_write(0, 0, 0, 1, 0, 0, 16'h7F02);
    do_acc(16'h2100, 16'h0000, 0, 0, 0, "R5");
    do_acc(16'h2100, 16'h0000, 0, 1, 0, "R5");
    do_read(2, 0, 0, 0, 0, 0, "R6");
    do_acc(16'h2100, 16'h0000, 0, 1, 1, "R5");
    do_acc(16'hA000, 16'h3000, 1, 0, 0, "R6");
    do_read(2, 0, 0, 0, 0, 0, "R6");
    // R7 non-resident
    do_write(0, 0, 0, 1, 0, 0, 16'h7F06);
    do_write(1, 0, 0, 1, 0, 0, 16'd3000);
    do_acc(16'h2000, 16'h0000, 0, 0, 0, "R7");
    do_read(2, 0, 0, 0, 0, 0, "R7");
    // R8 priority and strobe gating
    do_write(0, 0, 0, 1, 0, 0, 16'h7F00);
    do_acc(16'h2000, 16'h0000, 0, 0, 0, "R8");
    do_write(0, 0, 0, 1, 0, 0, 16'h0006);
    do_acc(16'h2100, 16'h0000, 0, 0, 0, "R8");
    do_read(0, 0, 0, 1, 0, 0, "R8");
    @(negedge clk);
    acc_valid = 0; vaddr = 16'h2100; #2;
    chk("R8", "abort without strobe", {31'd0, abort}, 32'd0);
    // R10 byte access
    do_write(1, 3, 0, 6, 1, 1, 16'h00AB);
    do_write(1, 3, 0, 6, 1, 0, 16'h00CD);
    do_read(1, 3, 0, 6, 0, 0, "R10");
    do_read(1, 3, 0, 6, 1, 1, "R10");
    do_read(1, 3, 0, 6, 1, 0, "R10");
    // R11 masks
    do_write(0, 1, 1, 3, 1, 0, 16'h00FF);
    do_read(0, 1, 1, 3, 0, 0, "R11");
    do_write(0, 0, 0, 2, 0, 0, 16'hFFFF);
    do_read(0, 0, 0, 2, 0, 0, "R11");
    lg_read(addr_of(0, 0, 0, 2), 16'o077516 & 16'hFF0F, "R11");
    do_write(1, 0, 0, 2, 0, 0, 16'hFFFF);
    do_read(1, 0, 0, 2, 0, 0, "R11");
    lg_read(addr_of(1, 0, 0, 2), 16'h0FFF, "R11");
    // R12 control register writes
    do_write(2, 0, 0, 0, 0, 0, 16'hFFFF);
    do_read(2, 0, 0, 0, 0, 0, "R12");
    do_write(2, 0, 0, 0, 0, 0, 16'hFFFE);
    do_read(2, 0, 0, 0, 0, 0, "R12");
    do_write(3, 0, 0, 0, 0, 0, 16'hFFFF);
    do_read(3, 0, 0, 0, 0, 0, "R12");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int op, md, kd, pg;
      bit ds, bm, od;
      logic [15:0] d;
      op = $urandom % 10;
      md = $urandom % 3; if (md == 2) md = 3;
      pg = $urandom % 8;
      ds = ($urandom % 4) == 0;
      bm = ($urandom % 4) == 0;
      od = bm & $urandom % 2;
      d  = 16'($urandom);
      if (op < 3) begin
        kd = $urandom % 2;
        if (kd == 1 && !bm) d = d & 16'h0FFF;
        do_write(kd, md, ds, pg, bm, od, d);
      end else if (op == 3) begin
        d[0] = ($urandom % 4) != 0;
        do_write(2, 0, 0, 0, 0, 0, d);
      end else if (op == 4) begin
        do_write(3, 0, 0, 0, bm, od, d);
      end else if (op < 7) begin
        kd = $urandom % 4;
        do_read(kd, md, ds, pg, bm, od, (bm ? "R10" : "R9"));
      end else begin
        do_acc(16'($urandom), 16'($urandom), $urandom % 2, $urandom % 2,
               ($urandom % 8) == 0, "R2");
      end
    end

    // R13 reset after traffic
    do_reset();
    do_read(2, 0, 0, 0, 0, 0, "R13");
    do_read(3, 0, 0, 0, 0, 0, "R13");
    do_read(0, 1, 0, 2, 0, 0, "R13");
    do_read(1, 0, 0, 1, 0, 0, "R13");
    do_acc(16'hABCD, 16'h0000, 0, 0, 0, "R13");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule